// File: doc/BRIEF.md
# Loop Add-Compare-Branch Unit

This block is the execution core for integer loop-control branches. Each request carries an opcode, a limit, an addend, the current loop index, a raw 16-bit displacement field, the current program counter and the incoming condition codes. The unit adds the step to the index at the operand size selected by the opcode, updates the condition codes from the new index, compares the new index against the limit, and produces the next program counter.

There are two kinds of operation. The general stepped form comes in byte, word and longword sizes. For it, the direction of the limit test follows the sign of the step. The two increment forms work on longwords only and use a step of one. One of them branches while the index is at or below the limit, the other while it is strictly below. The computation is combinational and lands in a single output register stage, qualified by a valid strobe, so a result appears one clock after its request. A new request can be issued every cycle. The surrounding pipeline fetches the operands and writes back the index, flags and program counter.

Top module: `loop_acb_unit`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. All result outputs change only on a clock edge where `in_valid` is high, and otherwise hold their last value.
- R2: The new index is the old index plus the step, wrapped at the operand size (byte = bits 7:0, word = bits 15:0, longword = bits 31:0). Bits of `in_index` above the operand size pass to `out_index` unchanged. The increment forms use a step of one and ignore `in_addend`.
- R3: `out_v` is set exactly when the signed addition overflows at the operand size.
- R4: `out_n` is the sign bit of the new index at the operand size. `out_z` is set when the new index is zero at the operand size. `out_c` equals `in_c`.
- R5: For the stepped form (opcodes 0x9D byte, 0x3D word, 0xF1 longword), when the step is zero or positive at the operand size, the branch is taken if the new index is less than or equal to the limit. When the step is negative, the branch is taken if the new index is greater than or equal to the limit. Both comparisons are signed and use the wrapped result and the sign-extended limit.
- R6: Opcode 0xF3 takes the branch when the new longword index is less than or equal to the limit, signed. Opcode 0xF2 takes it only when the new index is strictly less than the limit.
- R7: When the branch is taken, `out_pc` = `in_pc` + the sign-extended displacement. The stepped form uses all 16 bits of `in_displ`; the increment forms use bits 7:0. When the branch is not taken, `out_pc` = `in_pc`.
- R8: Any opcode other than 0x9D, 0x3D, 0xF1, 0xF3 or 0xF2 sets `out_illegal`. In that case `out_index` = `in_index`, the four flags equal the incoming flags, `out_taken` is 0 and `out_pc` = `in_pc`. For the supported opcodes `out_illegal` is 0.
- R9: While `rst_n` is low, `out_valid`, `out_taken` and `out_illegal` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe and result-register enable |
| in_opcode | input | 8 | Operation code |
| in_limit | input | 32 | Loop limit (low bits used at byte or word size) |
| in_addend | input | 32 | Step for the stepped form |
| in_index | input | 32 | Current loop index |
| in_displ | input | 16 | Raw branch displacement field |
| in_pc | input | 32 | Address of the next instruction |
| in_n | input | 1 | Incoming negative flag |
| in_z | input | 1 | Incoming zero flag |
| in_v | input | 1 | Incoming overflow flag |
| in_c | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Result valid |
| out_index | output | 32 | Updated index |
| out_n | output | 1 | Negative flag |
| out_z | output | 1 | Zero flag |
| out_v | output | 1 | Overflow flag |
| out_c | output | 1 | Carry flag (passed through) |
| out_taken | output | 1 | Branch taken |
| out_illegal | output | 1 | Unsupported opcode |
| out_pc | output | 32 | Next program counter |

## Verification
The bench sweeps every byte index against every byte step, and for part of that sweep it sets the limit equal to the new index. This catches three kinds of error: an off-by-one in the inclusive or strict limit test, a direction test keyed on the wrong sign, and a compare made on the unwrapped sum, which would branch wrongly after an overflow such as 0x7F + 1. Word and longword runs use the signed extremes, so they expose an overflow flag computed at the wrong size and upper index bits that get clobbered. The increment forms are fed a nonzero `in_addend` and a displacement whose high byte differs from the sign of its low byte, so a design that uses the wrong step or the wrong displacement width lands on a wrong index or a wrong target. Every unsupported opcode is swept to confirm that the index, the flags and the program counter pass through untouched.

// File: rtl/loop_acb_pkg.sv
package loop_acb_pkg;

  localparam logic [7:0] OPC_STEP_BYTE = 8'h9D;
  localparam logic [7:0] OPC_STEP_WORD = 8'h3D;
  localparam logic [7:0] OPC_STEP_LONG = 8'hF1;
  localparam logic [7:0] OPC_INC_LE    = 8'hF3;
  localparam logic [7:0] OPC_INC_LT    = 8'hF2;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2
  } opsize_e;

  typedef struct packed {
    logic    legal;
    opsize_e size;
    logic    inc_form;
    logic    strict_lt;
  } acb_dec_t;

endpackage

// File: rtl/loop_acb_decode.sv
module loop_acb_decode
  import loop_acb_pkg::*;
(
  input  logic [7:0] opcode,
  output acb_dec_t   dec
);

  always_comb begin
    dec = '{legal: 1'b1, size: SZ_LONG, inc_form: 1'b0, strict_lt: 1'b0};
    case (opcode)
      OPC_STEP_BYTE: dec.size = SZ_BYTE;
      OPC_STEP_WORD: dec.size = SZ_WORD;
      OPC_STEP_LONG: dec.size = SZ_LONG;
      OPC_INC_LE:    dec.inc_form = 1'b1;
      OPC_INC_LT: begin
        dec.inc_form  = 1'b1;
        dec.strict_lt = 1'b1;
      end
      default:       dec.legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/loop_acb_adder.sv
module loop_acb_adder
  import loop_acb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  opsize_e           size,
  input  logic [DATA_W-1:0] index,
  input  logic [DATA_W-1:0] step,
  output logic [DATA_W-1:0] sum_sext,
  output logic [DATA_W-1:0] merged_index,
  output logic              ovf,
  output logic              step_neg
);

  localparam int NSIZE = $clog2(DATA_W / 8) + 1;

  logic [DATA_W-1:0] sext_a  [NSIZE];
  logic [DATA_W-1:0] merge_a [NSIZE];
  logic              ovf_a   [NSIZE];
  logic              neg_a   [NSIZE];

  for (genvar g = 0; g < NSIZE; g++) begin : g_size
    localparam int W = 8 << g;
    logic [W-1:0] a_w, b_w, s_w;
    assign a_w = index[W-1:0];
    assign b_w = step[W-1:0];
    assign s_w = a_w + b_w;
    assign ovf_a[g] = (a_w[W-1] == b_w[W-1]) && (s_w[W-1] != a_w[W-1]);
    assign neg_a[g] = b_w[W-1];
    if (W < DATA_W) begin : g_part
      assign sext_a[g]  = {{(DATA_W-W){s_w[W-1]}}, s_w};
      assign merge_a[g] = {index[DATA_W-1:W], s_w};
    end else begin : g_full
      assign sext_a[g]  = s_w;
      assign merge_a[g] = s_w;
    end
  end

  always_comb begin
    sum_sext     = sext_a[NSIZE-1];
    merged_index = merge_a[NSIZE-1];
    ovf          = ovf_a[NSIZE-1];
    step_neg     = neg_a[NSIZE-1];
    for (int k = 0; k < NSIZE; k++) begin
      if (int'(size) == k) begin
        sum_sext     = sext_a[k];
        merged_index = merge_a[k];
        ovf          = ovf_a[k];
        step_neg     = neg_a[k];
      end
    end
  end

endmodule

// File: rtl/loop_acb_branch.sv
module loop_acb_branch
  import loop_acb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PC_W   = 32,
  parameter int DISP_W = 16
) (
  input  acb_dec_t          dec,
  input  logic [DATA_W-1:0] sum_sext,
  input  logic [DATA_W-1:0] limit,
  input  logic              step_neg,
  input  logic [DISP_W-1:0] displ,
  input  logic [PC_W-1:0]   pc,
  output logic              taken,
  output logic [PC_W-1:0]   next_pc
);

  localparam int NSIZE = $clog2(DATA_W / 8) + 1;

  logic [DATA_W-1:0] lim_a [NSIZE];
  logic [DATA_W-1:0] lim_sext;
  logic [PC_W-1:0]   disp_short, disp_long, disp_sel;
  logic              le, ge, lt;

  for (genvar g = 0; g < NSIZE; g++) begin : g_lim
    localparam int W = 8 << g;
    if (W < DATA_W) begin : g_part
      assign lim_a[g] = {{(DATA_W-W){limit[W-1]}}, limit[W-1:0]};
    end else begin : g_full
      assign lim_a[g] = limit;
    end
  end

  always_comb begin
    lim_sext = lim_a[NSIZE-1];
    for (int k = 0; k < NSIZE; k++) begin
      if (int'(dec.size) == k) lim_sext = lim_a[k];
    end
  end

  assign le = $signed(sum_sext) <= $signed(lim_sext);
  assign ge = $signed(sum_sext) >= $signed(lim_sext);
  assign lt = $signed(sum_sext) <  $signed(lim_sext);

  always_comb begin
    if (!dec.legal)        taken = 1'b0;
    else if (dec.inc_form) taken = dec.strict_lt ? lt : le;
    else                   taken = step_neg ? ge : le;
  end

  assign disp_short = {{(PC_W-8){displ[7]}}, displ[7:0]};
  assign disp_long  = {{(PC_W-DISP_W){displ[DISP_W-1]}}, displ};
  assign disp_sel   = dec.inc_form ? disp_short : disp_long;
  assign next_pc    = taken ? pc + disp_sel : pc;

endmodule

// File: rtl/loop_acb_unit.sv
module loop_acb_unit
  import loop_acb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PC_W   = 32,
  parameter int DISP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_opcode,
  input  logic [DATA_W-1:0] in_limit,
  input  logic [DATA_W-1:0] in_addend,
  input  logic [DATA_W-1:0] in_index,
  input  logic [DISP_W-1:0] in_displ,
  input  logic [PC_W-1:0]   in_pc,
  input  logic              in_n,
  input  logic              in_z,
  input  logic              in_v,
  input  logic              in_c,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_index,
  output logic              out_n,
  output logic              out_z,
  output logic              out_v,
  output logic              out_c,
  output logic              out_taken,
  output logic              out_illegal,
  output logic [PC_W-1:0]   out_pc
);

  acb_dec_t          dec;
  logic [DATA_W-1:0] step;
  logic [DATA_W-1:0] sum_sext, merged_index;
  logic              ovf, step_neg, taken;
  logic [PC_W-1:0]   next_pc;

  logic [DATA_W-1:0] index_d;
  logic              n_d, z_d, v_d, taken_d, illegal_d;
  logic [PC_W-1:0]   pc_d;

  loop_acb_decode u_dec (
    .opcode (in_opcode),
    .dec    (dec)
  );

  assign step = dec.inc_form ? DATA_W'(1) : in_addend;

  loop_acb_adder #(.DATA_W(DATA_W)) u_add (
    .size         (dec.size),
    .index        (in_index),
    .step         (step),
    .sum_sext     (sum_sext),
    .merged_index (merged_index),
    .ovf          (ovf),
    .step_neg     (step_neg)
  );

  loop_acb_branch #(.DATA_W(DATA_W), .PC_W(PC_W), .DISP_W(DISP_W)) u_br (
    .dec      (dec),
    .sum_sext (sum_sext),
    .limit    (in_limit),
    .step_neg (step_neg),
    .displ    (in_displ),
    .pc       (in_pc),
    .taken    (taken),
    .next_pc  (next_pc)
  );

  // next-state
  always_comb begin
    if (dec.legal) begin
      index_d   = merged_index;
      n_d       = sum_sext[DATA_W-1];
      z_d       = (sum_sext == '0);
      v_d       = ovf;
      taken_d   = taken;
      illegal_d = 1'b0;
      pc_d      = next_pc;
    end else begin
      index_d   = in_index;
      n_d       = in_n;
      z_d       = in_z;
      v_d       = in_v;
      taken_d   = 1'b0;
      illegal_d = 1'b1;
      pc_d      = in_pc;
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_taken   <= 1'b0;
      out_illegal <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_taken   <= taken_d;
        out_illegal <= illegal_d;
      end
    end
  end

  // datapath registers, enable only
  always_ff @(posedge clk) begin
    if (in_valid) begin
      out_index <= index_d;
      out_n     <= n_d;
      out_z     <= z_d;
      out_v     <= v_d;
      out_c     <= in_c;
      out_pc    <= pc_d;
    end
  end

endmodule

// File: rtl/loop_acb_unit_chk.sv
module loop_acb_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [7:0]  in_opcode,
  input logic [31:0] in_limit,
  input logic [31:0] in_pc,
  input logic        in_c,
  input logic        out_valid,
  input logic [31:0] out_index,
  input logic        out_n,
  input logic        out_z,
  input logic        out_c,
  input logic        out_taken,
  input logic        out_illegal,
  input logic [31:0] out_pc
);

  p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(out_pc) && $stable(out_taken));

  p_carry_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_c == $past(in_c));

  p_long_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (in_opcode == 8'hF1 || in_opcode == 8'hF2 || in_opcode == 8'hF3)
    |=> (out_z == (out_index == 32'd0)) && (out_n == out_index[31]));

  p_strict_less_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_opcode == 8'hF2
    |=> out_taken == ($signed(out_index) < $signed($past(in_limit))));

  p_fall_through_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_taken || out_pc == $past(in_pc));

  p_illegal_no_branch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> !out_taken);

endmodule

bind loop_acb_unit loop_acb_unit_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_opcode   (in_opcode),
  .in_limit    (in_limit),
  .in_pc       (in_pc),
  .in_c        (in_c),
  .out_valid   (out_valid),
  .out_index   (out_index),
  .out_n       (out_n),
  .out_z       (out_z),
  .out_c       (out_c),
  .out_taken   (out_taken),
  .out_illegal (out_illegal),
  .out_pc      (out_pc)
);

// File: tb/loop_acb_unit_tb.sv
module loop_acb_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  in_opcode;
  logic [31:0] in_limit, in_addend, in_index, in_pc;
  logic [15:0] in_displ;
  logic        in_n, in_z, in_v, in_c;
  logic        out_valid, out_n, out_z, out_v, out_c, out_taken, out_illegal;
  logic [31:0] out_index, out_pc;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  longint e_index, e_pc;
  bit     e_n, e_z, e_v, e_c, e_taken, e_ill;

  always #2 clk = ~clk;

  loop_acb_unit u_dut (.*);

  task automatic chk(string req, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic longint sx(longint x, int w);
    longint u;
    u = x & ((longint'(1) << w) - 1);
    if (u >= (longint'(1) << (w - 1))) return u - (longint'(1) << w);
    return u;
  endfunction

  task automatic model(logic [7:0] op, longint lim, longint add, longint idx,
                       longint dsp, longint pc, bit n, bit z, bit v, bit c);
    int w;
    bit inc, legal;
    longint mask, a, s, wr, ls, d;
    legal = 1'b1; inc = 1'b0; w = 32;
    case (op)
      8'h9D: w = 8;
      8'h3D: w = 16;
      8'hF1: w = 32;
      8'hF3, 8'hF2: inc = 1'b1;
      default: legal = 1'b0;
    endcase
    e_c = c;
    if (!legal) begin
      e_index = idx; e_n = n; e_z = z; e_v = v;
      e_taken = 1'b0; e_ill = 1'b1; e_pc = pc;
      return;
    end
    e_ill = 1'b0;
    mask = (longint'(1) << w) - 1;
    a  = inc ? 1 : sx(add, w);
    s  = sx(idx, w) + a;
    e_v = (s > (longint'(1) << (w - 1)) - 1) || (s < -(longint'(1) << (w - 1)));
    wr = sx(s, w);
    e_n = wr < 0;
    e_z = wr == 0;
    ls = sx(lim, w);
    if (op == 8'hF2)      e_taken = wr < ls;
    else if (op == 8'hF3) e_taken = wr <= ls;
    else if (a >= 0)      e_taken = wr <= ls;
    else                  e_taken = wr >= ls;
    e_index = (idx & ~mask & 64'hFFFF_FFFF) | (s & mask);
    d = inc ? sx(dsp, 8) : sx(dsp, 16);
    e_pc = e_taken ? ((pc + d) & 64'hFFFF_FFFF) : pc;
  endtask

  task automatic run(logic [7:0] op, logic [31:0] lim, logic [31:0] add,
                     logic [31:0] idx, logic [15:0] dsp, logic [31:0] pc,
                     logic [3:0] nzvc);
    in_valid = 1'b1; in_opcode = op; in_limit = lim; in_addend = add;
    in_index = idx; in_displ = dsp; in_pc = pc;
    {in_n, in_z, in_v, in_c} = nzvc;
    model(op, lim, add, idx, dsp, pc, nzvc[3], nzvc[2], nzvc[1], nzvc[0]);
    @(negedge clk);
    chk("R1 valid", out_valid, 1);
    chk("R2 index", out_index, e_index);
    chk("R3 overflow", out_v, e_v);
    chk("R4 n", out_n, e_n);
    chk("R4 z", out_z, e_z);
    chk("R4 c", out_c, e_c);
    chk(op == 8'hF2 || op == 8'hF3 ? "R6 taken" : "R5 taken", out_taken, e_taken);
    chk("R7 pc", out_pc, e_pc);
    chk("R8 illegal", out_illegal, e_ill);
  endtask

  longint wv[8] = '{0, 1, 2, 'h7FFF, 'h8000, 'hFFFF, 'h7FFE, 'h8001};
  longint wl[6] = '{0, 'h7FFF, 'h8000, 'hFFFF, 5, 'hFFFB};
  longint lv[8] = '{0, 1, 'hFFFF_FFFF, 'h7FFF_FFFF, 'h8000_0000,
                    'h7FFF_FFFE, 'hFFFF_FFFE, 'h0000_0100};

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_opcode = '0; in_limit = '0;
    in_addend = '0; in_index = '0; in_displ = '0; in_pc = '0;
    {in_n, in_z, in_v, in_c} = '0;
    repeat (3) @(negedge clk);
    chk("R9 reset valid", out_valid, 0);
    chk("R9 reset taken", out_taken, 0);
    chk("R9 reset illegal", out_illegal, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // byte sweep of the stepped form, R5
    for (int i = 0; i < 256; i++) begin
      for (int a = 0; a < 256; a++) begin
        logic [31:0] lim;
        lim = ((i + a) % 3 == 0) ? 32'((i + a) & 255) : 32'((i * 37 + a * 11) & 255);
        run(8'h9D, lim | 32'hA5A5_0000, 32'(a) | 32'h1200_0000,
            32'(i) | 32'hC3C3_3C00, 16'h8123 + 16'(i), 32'h0000_1000 + 32'(a),
            4'(i + a));
      end
    end

    // word corners
    foreach (wv[i]) foreach (wv[j]) foreach (wl[k])
      run(8'h3D, 32'(wl[k]), 32'(wv[j]) | 32'h00AB_0000, 32'(wv[i]) | 32'h5A5A_0000,
          16'h7F80 ^ 16'(k * 4099), 32'hFFFF_FFF0, 4'(i ^ j));

    // longword corners: stepped form and both increment forms (R6)
    foreach (lv[i]) foreach (lv[j]) begin
      run(8'hF1, 32'(lv[(i + j) % 8]), 32'(lv[j]), 32'(lv[i]), 16'hFF7E, 32'h8000_0000, 4'(j));
      run(8'hF3, 32'(lv[j]), 32'hDEAD_BEEF, 32'(lv[i]), 16'h7F85, 32'h0000_0040, 4'(i));
      run(8'hF2, 32'(lv[j]), 32'h8000_0000, 32'(lv[i]), 16'h0170, 32'h0000_0004, 4'(i + j));
      run(8'hF2, 32'(lv[i]) + 32'd1, 32'hFFFF_FFFF, 32'(lv[i]), 16'h00FE, 32'h0000_2000, 4'b0001);
      run(8'hF3, 32'(lv[i]) + 32'd1, 32'h0000_0005, 32'(lv[i]), 16'h0081, 32'h0000_2000, 4'b1110);
    end

    // unsupported opcodes, R8
    for (int op = 0; op < 256; op++) begin
      if (op != 'h9D && op != 'h3D && op != 'hF1 && op != 'hF2 && op != 'hF3)
        run(8'(op), 32'h10, 32'h1, 32'(op * 977), 16'h0010, 32'h0000_3000, 4'(op));
    end

    // idle cycles leave results alone, R1
    run(8'hF1, 32'd100, 32'd3, 32'd7, 16'h0020, 32'h0000_0500, 4'b0001);
    in_valid = 1'b0; in_index = 32'h1234_5678; in_pc = 32'h9999_0000;
    in_opcode = 8'hF2; in_c = 1'b0;
    repeat (2) begin
      @(negedge clk);
      chk("R1 idle valid", out_valid, 0);
      chk("R1 idle index", out_index, e_index);
      chk("R1 idle pc", out_pc, e_pc);
      chk("R1 idle taken", out_taken, e_taken);
      chk("R1 idle c", out_c, e_c);
    end

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule